// File: doc/BRIEF.md
# Data TLB Permission Fault Checker

This block watches the data-side address translation unit of a processor core at run time. Each time a translation lookup finishes, it takes the direction of the access and the current privilege level, and picks the one permission bit of the matched entry that applies. That bit is one of user read, supervisor read, user write or supervisor write. If the bit is clear, the core must raise its fault signal in the same cycle. When that fault is missing, the checker records a violation of the matching kind.

Each violation kind has its own tracker state machine with two states. `ST_CLEAN` means no missing fault has been seen. `ST_TRIPPED` means one has been seen, and the matching sticky flag is raised. A tracker takes the transition **trip** from `ST_CLEAN` to `ST_TRIPPED` on its first missed fault. It takes the self-transition **hold** in `ST_TRIPPED`, and only reset moves it back to `ST_CLEAN`. Each tracker also keeps a saturating count of missed faults, so tests can observe how often the fault was missing. An alarm output combines both flags. The checker does no translation and does no exception handling itself.

Top module: `dtlb_perm_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rd_viol`, `wr_viol` and `alarm` are 0 and both counters read 0.
- R2: A read (`acc_we`=0) in user mode (`priv_sup`=0) with `lkp_done`=1, `perm_ur`=0 and `core_fault`=0 sets `rd_viol` from the next cycle on, and it increments `rd_miss_cnt`.
- R3: A read in supervisor mode (`priv_sup`=1) with `lkp_done`=1, `perm_sr`=0 and `core_fault`=0 sets `rd_viol` from the next cycle on, and it increments `rd_miss_cnt`. `perm_ur` has no effect on this case.
- R4: A write (`acc_we`=1) in user mode with `lkp_done`=1, `perm_uw`=0 and `core_fault`=0 sets `wr_viol` from the next cycle on, and it increments `wr_miss_cnt`.
- R5: A write in supervisor mode with `lkp_done`=1, `perm_sw`=0 and `core_fault`=0 sets `wr_viol` from the next cycle on, and it increments `wr_miss_cnt`. `perm_uw` has no effect on this case.
- R6: When `lkp_done`=0, nothing changes: flags and counters keep their values whatever the other inputs are.
- R7: A lookup that has `core_fault`=1, or whose selected permission bit is set, changes no flag and no counter.
- R8: Once set, `rd_viol` and `wr_viol` stay set until `rst` is asserted.
- R9: Each counter is `CNT_W` bits wide. It increments by one per missed fault of its kind and holds at 2^`CNT_W`-1.
- R10: `alarm` equals `rd_viol` OR `wr_viol` in every cycle.
- R11: A read miss never changes `wr_viol` or `wr_miss_cnt`, and a write miss never changes `rd_viol` or `rd_miss_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lkp_done | input | 1 | Data translation lookup completes this cycle |
| acc_we | input | 1 | 1 for a write access, 0 for a read |
| priv_sup | input | 1 | 1 in supervisor mode, 0 in user mode |
| perm_ur | input | 1 | Entry allows user reads |
| perm_sr | input | 1 | Entry allows supervisor reads |
| perm_uw | input | 1 | Entry allows user writes |
| perm_sw | input | 1 | Entry allows supervisor writes |
| core_fault | input | 1 | Fault raised by the core for this access |
| rd_viol | output | 1 | Sticky flag: a denied read went without a fault |
| wr_viol | output | 1 | Sticky flag: a denied write went without a fault |
| alarm | output | 1 | OR of both violation flags |
| rd_miss_cnt | output | CNT_W | Saturating count of read misses |
| wr_miss_cnt | output | CNT_W | Saturating count of write misses |

## Verification
The bench builds the checker with `CNT_W`=4. With that width, both counters hit their ceiling of 15 within a short directed burst. Under random stimulus, the ceiling is also reached again many times between occasional resets. As a result, the saturation hold and the clearing of sticky state on reset are both exercised often. This is not the case at the default width of 8.

// File: rtl/dtlb_perm_guard_pkg.sv
package dtlb_perm_guard_pkg;

    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_TRIPPED = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic usr_rd;
        logic sup_rd;
        logic usr_wr;
        logic sup_wr;
    } perm_bits_t;

endpackage

// File: rtl/dpg_perm_sel.sv
module dpg_perm_sel
    import dtlb_perm_guard_pkg::*;
(
    input  logic       lkp_done,
    input  logic       acc_we,
    input  logic       priv_sup,
    input  perm_bits_t perm,
    input  logic       core_fault,
    output logic       rd_miss,
    output logic       wr_miss
);
    logic rd_allow;
    logic wr_allow;
    logic chk_en;

    // privilege picks which bit governs each direction
    always_comb begin
        rd_allow = priv_sup ? perm.sup_rd : perm.usr_rd;
        wr_allow = priv_sup ? perm.sup_wr : perm.usr_wr;
        chk_en   = lkp_done && !core_fault;
        rd_miss  = chk_en && !acc_we && !rd_allow;
        wr_miss  = chk_en &&  acc_we && !wr_allow;
    end
endmodule

// File: rtl/dpg_viol_track.sv
module dpg_viol_track
    import dtlb_perm_guard_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss,
    output logic             flag,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    trk_state_e state_q;
    trk_state_e state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CLEAN;
        else     state_q <= state_d;
    end

    // transitions: trip on first miss, hold thereafter
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN:   if (miss) state_d = ST_TRIPPED;
            ST_TRIPPED: state_d = ST_TRIPPED;
            default:    state_d = ST_CLEAN;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_TRIPPED: flag = 1'b1;
            default:    flag = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (miss && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dtlb_perm_guard.sv
module dtlb_perm_guard
    import dtlb_perm_guard_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lkp_done,
    input  logic             acc_we,
    input  logic             priv_sup,
    input  logic             perm_ur,
    input  logic             perm_sr,
    input  logic             perm_uw,
    input  logic             perm_sw,
    input  logic             core_fault,
    output logic             rd_viol,
    output logic             wr_viol,
    output logic             alarm,
    output logic [CNT_W-1:0] rd_miss_cnt,
    output logic [CNT_W-1:0] wr_miss_cnt
);
    localparam int N_KIND = 2;

    perm_bits_t       perm;
    logic [N_KIND-1:0] miss_vec;
    logic [N_KIND-1:0] flag_vec;
    logic [CNT_W-1:0]  cnt_arr [N_KIND];

    assign perm = '{usr_rd: perm_ur, sup_rd: perm_sr, usr_wr: perm_uw, sup_wr: perm_sw};

    dpg_perm_sel u_sel (
        .lkp_done  (lkp_done),
        .acc_we    (acc_we),
        .priv_sup  (priv_sup),
        .perm      (perm),
        .core_fault(core_fault),
        .rd_miss   (miss_vec[0]),
        .wr_miss   (miss_vec[1])
    );

    // index 0 tracks reads, index 1 tracks writes
    for (genvar k = 0; k < N_KIND; k++) begin : g_trk
        dpg_viol_track #(.CNT_W(CNT_W)) u_trk (
            .clk (clk),
            .rst (rst),
            .miss(miss_vec[k]),
            .flag(flag_vec[k]),
            .cnt (cnt_arr[k])
        );
    end

    assign rd_viol     = flag_vec[0];
    assign wr_viol     = flag_vec[1];
    assign rd_miss_cnt = cnt_arr[0];
    assign wr_miss_cnt = cnt_arr[1];
    assign alarm       = |flag_vec;
endmodule

// File: rtl/dtlb_perm_guard_chk.sv
module dtlb_perm_guard_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             lkp_done,
    input logic             acc_we,
    input logic             priv_sup,
    input logic             perm_ur,
    input logic             perm_sr,
    input logic             perm_uw,
    input logic             perm_sw,
    input logic             core_fault,
    input logic             rd_viol,
    input logic             wr_viol,
    input logic             alarm,
    input logic [CNT_W-1:0] rd_miss_cnt,
    input logic [CNT_W-1:0] wr_miss_cnt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    p_usr_rd_r2: assert property (@(posedge clk) disable iff (rst)
        lkp_done && !acc_we && !priv_sup && !perm_ur && !core_fault |=> rd_viol);
    p_sup_rd_r3: assert property (@(posedge clk) disable iff (rst)
        lkp_done && !acc_we && priv_sup && !perm_sr && !core_fault |=> rd_viol);
    p_usr_wr_r4: assert property (@(posedge clk) disable iff (rst)
        lkp_done && acc_we && !priv_sup && !perm_uw && !core_fault |=> wr_viol);
    p_sup_wr_r5: assert property (@(posedge clk) disable iff (rst)
        lkp_done && acc_we && priv_sup && !perm_sw && !core_fault |=> wr_viol);
    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !lkp_done |=> $stable(rd_miss_cnt) && $stable(wr_miss_cnt));
    p_faulted_r7: assert property (@(posedge clk) disable iff (rst)
        core_fault |=> $stable(rd_miss_cnt) && $stable(wr_miss_cnt));
    p_sticky_rd_r8: assert property (@(posedge clk) disable iff (rst)
        rd_viol |=> rd_viol);
    p_sticky_wr_r8: assert property (@(posedge clk) disable iff (rst)
        wr_viol |=> wr_viol);
    p_sat_r9: assert property (@(posedge clk) disable iff (rst)
        rd_miss_cnt == TOP |=> rd_miss_cnt == TOP);
    p_alarm_r10: assert property (@(posedge clk) disable iff (rst)
        alarm == (rd_viol || wr_viol));
    p_sep_rd_r11: assert property (@(posedge clk) disable iff (rst)
        !acc_we |=> $stable(wr_miss_cnt));
    p_sep_wr_r11: assert property (@(posedge clk) disable iff (rst)
        acc_we |=> $stable(rd_miss_cnt));
endmodule

bind dtlb_perm_guard dtlb_perm_guard_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dtlb_perm_guard_tb_top.sv
module dtlb_perm_guard_tb_top;
    localparam int CW = 4;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lkp_done = 0, acc_we = 0, priv_sup = 0, core_fault = 0;
    logic perm_ur = 1, perm_sr = 1, perm_uw = 1, perm_sw = 1;
    logic rd_viol, wr_viol, alarm;
    logic [CW-1:0] rd_miss_cnt, wr_miss_cnt;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic e_rd, e_wr;
    logic [CW-1:0] e_rc, e_wc;

    always #10 clk = ~clk;   // 50 MHz

    dtlb_perm_guard #(.CNT_W(CW)) dut_i (.*);

    function automatic logic denied(input logic we, sup, ur, sr, uw, sw);
        if (!we) return sup ? !sr : !ur;
        return sup ? !sw : !uw;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2/R3/R8 rd_viol", rd_viol, e_rd);
        chk("R4/R5/R8 wr_viol", wr_viol, e_wr);
        chk("R9/R11 rd_miss_cnt", rd_miss_cnt, e_rc);
        chk("R9/R11 wr_miss_cnt", wr_miss_cnt, e_wc);
        chk("R10 alarm", alarm, e_rd | e_wr);
    endtask

    // drive at negedge, model at posedge, check at next negedge
    task automatic step(input logic r, ld, we, sup, ur, sr, uw, sw, flt);
        rst = r; lkp_done = ld; acc_we = we; priv_sup = sup;
        perm_ur = ur; perm_sr = sr; perm_uw = uw; perm_sw = sw; core_fault = flt;
        @(posedge clk);
        if (r) begin
            e_rd = 0; e_wr = 0; e_rc = 0; e_wc = 0;
        end else if (ld && !flt && denied(we, sup, ur, sr, uw, sw)) begin
            if (!we) begin e_rd = 1; if (e_rc != CMAX) e_rc++; end
            else     begin e_wr = 1; if (e_wc != CMAX) e_wc++; end
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'd2024));
        e_rd = 0; e_wr = 0; e_rc = 0; e_wc = 0;
        @(negedge clk);
        step(1, 0, 0, 0, 1, 1, 1, 1, 0);                 // R1 during reset
        step(0, 0, 0, 0, 1, 1, 1, 1, 0);                 // R1 after reset
        chk("R1 rd_viol reset", rd_viol, 0);
        step(0, 1, 0, 0, 0, 1, 1, 1, 0);                 // R2 user read denied
        chk("R2 rd set", rd_viol, 1);
        chk("R11 wr untouched", wr_viol, 0);
        step(1, 0, 0, 0, 1, 1, 1, 1, 0);
        step(0, 1, 0, 1, 1, 0, 1, 1, 0);                 // R3 sup read, ur set
        chk("R3 rd set", rd_viol, 1);
        step(1, 0, 0, 0, 1, 1, 1, 1, 0);
        step(0, 1, 1, 0, 1, 1, 0, 1, 0);                 // R4 user write
        chk("R4 wr set", wr_viol, 1);
        chk("R11 rd untouched", rd_viol, 0);
        step(1, 0, 0, 0, 1, 1, 1, 1, 0);
        step(0, 1, 1, 1, 1, 1, 1, 0, 0);                 // R5 sup write, uw set
        chk("R5 wr set", wr_viol, 1);
        step(1, 0, 0, 0, 1, 1, 1, 1, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);                 // R6 no lookup
        step(0, 0, 1, 1, 0, 0, 0, 0, 0);
        chk("R6 idle", alarm, 0);
        step(0, 1, 0, 0, 0, 0, 0, 0, 1);                 // R7 faulted
        step(0, 1, 0, 1, 0, 1, 0, 0, 0);                 // R7 permitted sup read
        step(0, 1, 1, 0, 0, 0, 1, 0, 0);                 // R7 permitted user write
        chk("R7 no flag", alarm, 0);
        step(0, 1, 0, 0, 0, 1, 1, 1, 0);                 // R8 trip then hold
        for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 1, 1, 1, 1, 0);
        chk("R8 sticky", rd_viol, 1);
        step(1, 0, 0, 0, 1, 1, 1, 1, 0);
        chk("R8 cleared", rd_viol, 0);
        for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 0, 1, 1, 1, 0);   // R9
        for (int i = 0; i < 18; i++) step(0, 1, 1, 1, 1, 1, 1, 0, 0);
        chk("R9 rd sat", rd_miss_cnt, CMAX);
        chk("R9 wr sat", wr_miss_cnt, CMAX);
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 150) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
                 $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                 ($urandom % 4) == 0);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule